// File: doc/BRIEF.md
# AC-Link Reset and Wake Sequencer

This block runs the controller side of the reset and wake-up protocol of an AC97-style serial audio link. Software control bits request a cold reset or a warm reset. A cold reset drives the active-low codec reset pin directly. A warm reset raises SYNC for a timed interval, and it is allowed only while the codec bit clock is stopped. The block runs on a free-running system clock. It treats the codec bit clock, the wake line and the SYNC readback as asynchronous levels and passes each of them through a two-flop synchronizer.

Bit-clock presence comes from an edge detector with a timeout. The block reports the link as active only when all of the following hold: the bit clock is toggling, the codec reset pin is released, and any warm reset has finished with SYNC sampled low again. This last condition stops the first frame boundary from being detected falsely. A rising edge on the wake line sets a sticky interrupt when resume interrupts are enabled. Software then picks which reset to issue.

Top module: `aclink_rst_seq`

## Requirements
- R1: While `cold_rst_i` is 1, `codec_rst_no` is 0 from the next clock edge on. It returns to 1 one edge after `cold_rst_i` returns to 0. During `rst_ni` low it is 0.
- R2: While `cold_rst_i` is 1, the wake interrupt and the error status are cleared to 0. An ongoing warm reset is also aborted, so `sync_o` drops to 0 on the next edge.
- R3: A one-cycle `warm_req_i` taken while the bit clock is absent raises `sync_o` for exactly WARM_CYC consecutive system clocks. WARM_CYC = ceil(SYS_CLK_HZ × WARM_NS / 1e9). With SYS_CLK_HZ = 12.5 MHz and WARM_NS = 1000 this is 13.
- R4: A `warm_req_i` made while the bit clock is present has no effect on `sync_o`, which stays 0. It sets `err_o` to 1, and `err_o` stays 1 until a cycle with `err_clr_i` = 1.
- R5: The bit clock counts as present once a synchronized edge on `bitclk_i` is seen. It counts as absent after BCLK_TIMEOUT system clocks with no edge. `link_active_o` is 0 whenever the bit clock is absent.
- R6: During a warm reset `link_active_o` stays 0, even if the bit clock restarts. It may rise only after the synchronized readback of SYNC has been low on two consecutive samples.
- R7: A rising edge on `wake_i` sets `irq_o` only if `resume_ie_i` is 1 at that time. `irq_o` then holds until a cycle with `wake_clr_i` = 1, and a new set in the same cycle wins over the clear.
- R8: `link_active_o` is 1 only while `codec_rst_no` is 1 and `sync_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bitclk_i | input | 1 | Codec bit clock, asynchronous |
| wake_i | input | 1 | Codec wake indication, asynchronous level |
| cold_rst_i | input | 1 | Software cold-reset bit (level) |
| warm_req_i | input | 1 | Software warm-reset request (one-cycle pulse) |
| resume_ie_i | input | 1 | Resume interrupt enable |
| wake_clr_i | input | 1 | Write-one-to-clear for the wake interrupt |
| err_clr_i | input | 1 | Write-one-to-clear for the warm-reset error |
| codec_rst_no | output | 1 | Active-low codec reset pin |
| sync_o | output | 1 | SYNC line (warm-reset pulse) |
| link_active_o | output | 1 | Link may start frame detection |
| irq_o | output | 1 | Sticky wake-up interrupt |
| err_o | output | 1 | Sticky warm-request-while-clocked error |

## Verification
The assertions check on every cycle the invariants that tie the outputs together:
- the link is never active while SYNC is high, while the reset pin is asserted, or while the bit clock is absent;
- a cold reset forces the pin low and clears both status bits;
- SYNC rises only while the bit clock is absent, and every pulse that ends without a cold abort is exactly WARM_CYC cycles long;
- the interrupt rises only with the enable set.

Some behaviours only the bench scenarios can show. These are the timeout-driven change from present to absent, a bit clock that restarts mid-pulse and holds off link activation, a warm request that is ignored while the clock runs, and an abort by a cold reset.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  typedef enum logic [1:0] {
    W_IDLE     = 2'd0,
    W_PULSE    = 2'd1,
    W_WAIT_LOW = 2'd2
  } warm_st_e;

  function automatic int unsigned ceil_cycles(longint unsigned hz, longint unsigned ns);
    return int'((hz * ns + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction
endpackage

// File: rtl/aclink_edge_sync.sv
module aclink_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic prev_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= async_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign level_o = s2_q;
  assign prev_o  = s3_q;
endmodule

// File: rtl/aclink_bclk_mon.sv
module aclink_bclk_mon #(
  parameter int unsigned TIMEOUT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bitclk_i,
  output logic present_o
);
  localparam int unsigned TW = $clog2(TIMEOUT + 1);

  logic          lvl, prv, edge_seen;
  logic [TW-1:0] idle_cnt_q;

  aclink_edge_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(bitclk_i),
    .level_o(lvl),
    .prev_o (prv)
  );

  assign edge_seen = lvl ^ prv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_cnt_q <= '0;
      present_o  <= 1'b0;
    end else if (edge_seen) begin
      idle_cnt_q <= '0;
      present_o  <= 1'b1;
    end else if (idle_cnt_q == TW'(TIMEOUT - 1)) begin
      present_o  <= 1'b0;
    end else begin
      idle_cnt_q <= idle_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/aclink_warm_gen.sv
module aclink_warm_gen
  import aclink_pkg::*;
#(
  parameter int unsigned WARM_CYC = 13
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  output logic sync_o,
  output logic idle_o
);
  localparam int unsigned CW = $clog2(WARM_CYC + 1);

  warm_st_e      st_q;
  logic [CW-1:0] cnt_q;
  logic          rb_lvl, rb_prv;

  // SYNC pad readback, treated as asynchronous while the bit clock is off
  aclink_edge_sync u_rb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(sync_o),
    .level_o(rb_lvl),
    .prev_o (rb_prv)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= W_IDLE;
      cnt_q <= '0;
    end else if (abort_i) begin
      st_q  <= W_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        W_IDLE: if (start_i) begin
          st_q  <= W_PULSE;
          cnt_q <= '0;
        end
        W_PULSE: if (cnt_q == CW'(WARM_CYC - 1)) st_q <= W_WAIT_LOW;
                 else cnt_q <= cnt_q + 1'b1;
        W_WAIT_LOW: if (!rb_lvl && !rb_prv) st_q <= W_IDLE;
        default: st_q <= W_IDLE;
      endcase
    end
  end

  assign sync_o = (st_q == W_PULSE);
  assign idle_o = (st_q == W_IDLE);
endmodule

// File: rtl/aclink_rst_seq.sv
module aclink_rst_seq
  import aclink_pkg::*;
#(
  parameter int unsigned SYS_CLK_HZ   = 50_000_000,
  parameter int unsigned WARM_NS      = 1000,
  parameter int unsigned BCLK_TIMEOUT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bitclk_i,
  input  logic wake_i,
  input  logic cold_rst_i,
  input  logic warm_req_i,
  input  logic resume_ie_i,
  input  logic wake_clr_i,
  input  logic err_clr_i,
  output logic codec_rst_no,
  output logic sync_o,
  output logic link_active_o,
  output logic irq_o,
  output logic err_o
);
  localparam int unsigned WARM_CYC = ceil_cycles(SYS_CLK_HZ, WARM_NS);

  logic bclk_present, warm_idle, wake_lvl, wake_prv, wake_rise;

  aclink_bclk_mon #(.TIMEOUT(BCLK_TIMEOUT)) u_bclk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bitclk_i (bitclk_i),
    .present_o(bclk_present)
  );

  aclink_warm_gen #(.WARM_CYC(WARM_CYC)) u_warm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(warm_req_i && !bclk_present),
    .abort_i(cold_rst_i),
    .sync_o (sync_o),
    .idle_o (warm_idle)
  );

  aclink_edge_sync u_wake (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(wake_i),
    .level_o(wake_lvl),
    .prev_o (wake_prv)
  );

  assign wake_rise = wake_lvl && !wake_prv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      codec_rst_no <= 1'b0;
      irq_o        <= 1'b0;
      err_o        <= 1'b0;
    end else begin
      codec_rst_no <= !cold_rst_i;
      if (cold_rst_i) begin
        irq_o <= 1'b0;
        err_o <= 1'b0;
      end else begin
        if (wake_rise && resume_ie_i) irq_o <= 1'b1;
        else if (wake_clr_i)          irq_o <= 1'b0;
        if (warm_req_i && bclk_present) err_o <= 1'b1;
        else if (err_clr_i)             err_o <= 1'b0;
      end
    end
  end

  assign link_active_o = bclk_present && codec_rst_no && warm_idle;
endmodule

// File: rtl/aclink_rst_seq_chk.sv
module aclink_rst_seq_chk #(
  parameter int unsigned WARM_CYC = 13
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cold_rst_i,
  input logic resume_ie_i,
  input logic codec_rst_no,
  input logic sync_o,
  input logic link_active_o,
  input logic irq_o,
  input logic err_o,
  input logic bclk_present
);
  int unsigned hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_cnt <= 0;
    else if (sync_o) hi_cnt <= hi_cnt + 1;
    else hi_cnt <= 0;
  end

  AST_COLD_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cold_rst_i |=> !codec_rst_no);  // R1
  AST_COLD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cold_rst_i |=> (!irq_o && !err_o && !sync_o));  // R2
  AST_PULSE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sync_o) && !$past(cold_rst_i)) |-> (hi_cnt == WARM_CYC));  // R3
  AST_WARM_ONLY_UNCLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> !$past(bclk_present));  // R4
  AST_LINK_NEEDS_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_active_o |-> bclk_present);  // R5
  AST_LINK_QUIET_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_active_o |-> !sync_o);  // R6
  AST_IRQ_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(resume_ie_i));  // R7
  AST_LINK_PIN_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_active_o |-> codec_rst_no);  // R8
endmodule

bind aclink_rst_seq aclink_rst_seq_chk #(.WARM_CYC(WARM_CYC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cold_rst_i   (cold_rst_i),
  .resume_ie_i  (resume_ie_i),
  .codec_rst_no (codec_rst_no),
  .sync_o       (sync_o),
  .link_active_o(link_active_o),
  .irq_o        (irq_o),
  .err_o        (err_o),
  .bclk_present (bclk_present)
);

// File: tb/tb_aclink_rst_seq.sv
module tb_aclink_rst_seq;
  localparam int CLK_PERIOD = 10;
  localparam int SYS_HZ     = 12_500_000;
  localparam int EXP_WIDTH  = 13;   // ceil(12.5 MHz * 1 us)
  localparam int TIMEOUT    = 16;

  // {cold, ie, wake_pulse, wake_clr, exp_irq, exp_rst_n}
  localparam int NV = 6;
  localparam logic [5:0] VEC [NV] = '{
    6'b0_1_1_0_1_1,  // R7 set with enable
    6'b0_0_0_1_0_1,  // R7 clear
    6'b0_0_1_0_0_1,  // R7 disabled edge ignored
    6'b0_1_1_0_1_1,  // R7 set again
    6'b1_1_0_0_0_0,  // R1 R2 cold clears, pin low
    6'b0_1_0_0_0_1   // R1 pin released
  };

  logic clk = 0, rst_ni = 0, bitclk = 0, wake = 0, cold = 0, warm_req = 0;
  logic ie = 0, wclr = 0, eclr = 0, bclk_en = 0;
  logic codec_rst_no, sync_o, link_active_o, irq_o, err_o;
  int n_chk = 0, n_bad = 0;

  aclink_rst_seq #(.SYS_CLK_HZ(SYS_HZ), .WARM_NS(1000), .BCLK_TIMEOUT(TIMEOUT)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .bitclk_i(bitclk), .wake_i(wake),
    .cold_rst_i(cold), .warm_req_i(warm_req), .resume_ie_i(ie),
    .wake_clr_i(wclr), .err_clr_i(eclr), .codec_rst_no(codec_rst_no),
    .sync_o(sync_o), .link_active_o(link_active_o), .irq_o(irq_o), .err_o(err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  initial forever begin
    #(2*CLK_PERIOD + 3);
    if (bclk_en) bitclk = ~bitclk;
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic warm_pulse();
    warm_req = 1; cyc(1); warm_req = 0;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    n_bad++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int width;
    cyc(3);
    chk("R1 reset pin", codec_rst_no, 0);
    chk("R3 reset sync", sync_o, 0);
    chk("R5 reset link", link_active_o, 0);
    chk("R7 reset irq", irq_o, 0);
    chk("R4 reset err", err_o, 0);
    rst_ni = 1; cyc(2);
    chk("R1 pin released", codec_rst_no, 1);

    for (int i = 0; i < NV; i++) begin
      cold = VEC[i][5]; ie = VEC[i][4]; wclr = VEC[i][2];
      if (VEC[i][3]) wake = 1;
      cyc(4); wake = 0; wclr = 0; cyc(4);
      chk($sformatf("R7 vec%0d irq", i), irq_o, VEC[i][1]);
      chk($sformatf("R1 vec%0d pin", i), codec_rst_no, VEC[i][0]);
    end
    cold = 0; ie = 0; cyc(2);

    // R3 width, R6 link held low during pulse
    warm_pulse();
    width = 0;
    for (int k = 0; k < 40; k++) begin
      if (sync_o) begin
        width++;
        if (width == 5) chk("R6 link during pulse", link_active_o, 0);
      end
      cyc(1);
    end
    chk("R3 pulse width", width, EXP_WIDTH);
    chk("R5 link low, clock absent", link_active_o, 0);
    bclk_en = 1; cyc(20);
    chk("R5 link up, clock present", link_active_o, 1);

    // R4 ignored while clocked
    warm_pulse();
    width = 0;
    for (int k = 0; k < 20; k++) begin
      width += int'(sync_o);
      cyc(1);
    end
    chk("R4 sync unchanged", width, 0);
    chk("R4 err set", err_o, 1);
    chk("R4 link kept", link_active_o, 1);
    eclr = 1; cyc(1); eclr = 0; cyc(1);
    chk("R4 err cleared", err_o, 0);

    // R8 / R1 cold while active
    cold = 1; cyc(3);
    chk("R8 link low under cold", link_active_o, 0);
    chk("R1 pin low under cold", codec_rst_no, 0);
    cold = 0; cyc(3);
    chk("R8 link back", link_active_o, 1);

    // R5 timeout
    bclk_en = 0; cyc(TIMEOUT + 12);
    chk("R5 absent after timeout", link_active_o, 0);

    // R6 clock restarts mid-pulse
    warm_pulse();
    cyc(1); bclk_en = 1; cyc(8);
    chk("R6 sync still high", sync_o, 1);
    chk("R6 link held during pulse", link_active_o, 0);
    cyc(15);
    chk("R6 link after sync low", link_active_o, 1);

    // R2 cold aborts warm pulse
    bclk_en = 0; cyc(TIMEOUT + 12);
    warm_pulse(); cyc(3);
    chk("R2 pulse started", sync_o, 1);
    cold = 1; cyc(2);
    chk("R2 pulse aborted", sync_o, 0);
    cold = 0; cyc(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule